// File: doc/BRIEF.md
# Timekeeper Bus Register and Alarm Front End

This block sits between an APB bus running at 16 MHz and a calendar counter that lives on a slow 32.768 kHz clock. It keeps a bus-side copy of the date and time. The copy is refreshed whenever the slow domain signals that a second has passed. A bus read at the timekeeper address returns that copy as one 32-bit word.

A bus write at the same address is decoded by its two top data bits. One code hands a new date and time to the slow domain over a toggle handshake. Another code stores an alarm value and arms the alarm. The two remaining codes do nothing. The alarm compares hour, minute and second with each fresh time value and raises a sticky interrupt on a match.

The slow domain is expected to change `cal_time_i` only at the moment it raises `sec_tick_i`. It holds both the value and the tick level for at least three bus clocks. It answers a time-set request by toggling `set_ack_i` once it has taken `set_val_o`.

Top module: `rtc_apb_regs`

## Requirements
- R1: Time word packing, used for reads, time-set writes and alarm writes: bits [29:26] hold the year minus 2017, [25:22] the month, [21:17] the day, [16:12] the hour, [11:6] the minute and [5:0] the second. Read bits [31:30] are always 0. After reset, a read returns 01/01/2017 00:00:00, which is 0x00420000.
- R2: PREADY is high in every access phase (PSEL and PENABLE both high), for reads and for writes, so no transfer has wait states.
- R3: The bus-side time copy takes the value of `cal_time_i` within 4 clocks of a rising edge on `sec_tick_i`. It does not change at any other time, even when `cal_time_i` changes.
- R4: A read at any address other than `TK_ADDR` returns 0. A read outside an access phase also drives 0 on PRDATA. A write to any other address has no effect.
- R5: A write with code 01 in bits [31:30] loads `set_val_o` with bits [29:0] and toggles `set_req_o`, as long as no earlier request is still waiting.
- R6: While `set_req_o` differs from the synchronized `set_ack_i`, `set_val_o` and `set_req_o` stay stable. A further code-01 write is dropped.
- R7: Writes with code 00 or 11 change no state: no request is made and the alarm is neither stored nor armed.
- R8: A write with code 10 stores bits [16:0] as the alarm and arms it. When an armed alarm's hour, minute and second equal those of a new time value at a tick, `alarm_irq_o` goes high. The date fields play no part in the match.
- R9: `alarm_irq_o` stays high across later ticks. It is cleared only by the next code-10 write or by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W | APB address |
| pwdata | input | 32 | Write data: function code in [31:30], time word in [29:0] |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer complete |
| sec_tick_i | input | 1 | One-second tick level from the slow domain |
| cal_time_i | input | 30 | Live packed time from the calendar counter |
| set_val_o | output | 30 | Packed time to load into the counter |
| set_req_o | output | 1 | Load request, toggled once per request |
| set_ack_i | input | 1 | Load acknowledge, toggled by the slow domain |
| alarm_irq_o | output | 1 | Alarm interrupt to the CPU |

## Verification
The bench drives `cal_time_i` to a new value without a tick and then reads. A design that copies the live counter on every cycle would return the fresh value here instead of the held one. It issues a second time-set write while the first request is still unacknowledged. A design with no busy guard would overwrite `set_val_o` under the slow domain's feet. Alarms are placed so that hour, minute and second match while the date differs, and so that a later tick no longer matches. This catches a full-word compare and an interrupt that drops by itself. Writes with the reserved codes and writes to a wrong address are each followed by a tick or a read that would expose any stray load, arm or request.

// File: rtl/rtc_apb_regs.sv
module rtc_apb_regs #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] TK_ADDR = 12'h010,
  parameter logic [29:0] RESET_TIME = 30'h0042_0000
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  input  logic              sec_tick_i,
  input  logic [29:0]       cal_time_i,
  output logic [29:0]       set_val_o,
  output logic              set_req_o,
  input  logic              set_ack_i,
  output logic              alarm_irq_o
);
  localparam logic [1:0] FN_SET = 2'b01;
  localparam logic [1:0] FN_ALM = 2'b10;
  localparam int HMS_W = 17;

  logic [2:0]       tick_sync;
  logic [1:0]       ack_sync;
  logic [29:0]      snap;
  logic [HMS_W-1:0] alarm_q;
  logic             armed;

  wire access    = psel & penable;
  wire hit       = (paddr == TK_ADDR);
  wire wr_go     = access & pwrite & hit;
  wire rd_go     = access & ~pwrite & hit;
  wire [1:0] fn  = pwdata[31:30];
  wire tick_edge = tick_sync[1] & ~tick_sync[2];
  wire busy      = set_req_o ^ ack_sync[1];
  wire match     = armed & (cal_time_i[HMS_W-1:0] == alarm_q);

  assign pready = access;
  assign prdata = rd_go ? {2'b00, snap} : 32'd0;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      tick_sync <= '0;
      ack_sync  <= '0;
    end else begin
      tick_sync <= {tick_sync[1:0], sec_tick_i};
      ack_sync  <= {ack_sync[0], set_ack_i};
    end
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn)
      snap <= RESET_TIME;
    else if (tick_edge)
      snap <= cal_time_i;
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      set_val_o <= '0;
      set_req_o <= 1'b0;
    end else if (wr_go && fn == FN_SET && !busy) begin
      set_val_o <= pwdata[29:0];
      set_req_o <= ~set_req_o;
    end
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      alarm_q     <= '0;
      armed       <= 1'b0;
      alarm_irq_o <= 1'b0;
    end else if (wr_go && fn == FN_ALM) begin
      alarm_q     <= pwdata[HMS_W-1:0];
      armed       <= 1'b1;
      alarm_irq_o <= 1'b0;
    end else if (tick_edge && match) begin
      alarm_irq_o <= 1'b1;
    end
  end
endmodule

module rtc_apb_regs_chk (
  input logic        pclk,
  input logic        presetn,
  input logic        psel,
  input logic        penable,
  input logic        pwrite,
  input logic        hit,
  input logic [1:0]  fcode,
  input logic [31:0] prdata,
  input logic        pready,
  input logic        tick_edge,
  input logic        busy,
  input logic [29:0] snap,
  input logic [29:0] set_val_o,
  input logic        set_req_o,
  input logic        alarm_irq_o
);
  // R2
  ready_in_access_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable) |-> pready);
  // R4
  quiet_rdata_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (prdata != 32'd0) |-> (psel && penable && !pwrite && hit));
  // R3
  snap_on_tick_chk: assert property (@(posedge pclk) disable iff (!presetn)
    !$stable(snap) |-> $past(tick_edge));
  // R5
  req_from_set_chk: assert property (@(posedge pclk) disable iff (!presetn)
    !$stable(set_req_o) |-> $past(psel && penable && pwrite && hit && fcode == 2'b01));
  // R6
  hold_while_busy_chk: assert property (@(posedge pclk) disable iff (!presetn)
    busy |=> ($stable(set_val_o) && $stable(set_req_o)));
  // R8
  irq_on_tick_chk: assert property (@(posedge pclk) disable iff (!presetn)
    $rose(alarm_irq_o) |-> $past(tick_edge));
  // R9
  irq_clear_chk: assert property (@(posedge pclk) disable iff (!presetn)
    $fell(alarm_irq_o) |-> $past(psel && penable && pwrite && hit && fcode == 2'b10));
endmodule

bind rtc_apb_regs rtc_apb_regs_chk u_chk (
  .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
  .pwrite(pwrite), .hit(hit), .fcode(pwdata[31:30]), .prdata(prdata),
  .pready(pready), .tick_edge(tick_edge), .busy(busy), .snap(snap),
  .set_val_o(set_val_o), .set_req_o(set_req_o), .alarm_irq_o(alarm_irq_o)
);

// File: tb/rtc_apb_regs_tb.sv
module rtc_apb_regs_tb;
  localparam logic [11:0] TK = 12'h010;

  logic pclk = 0, presetn = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic pready, sec_tick_i = 0, set_ack_i = 0, set_req_o, alarm_irq_o;
  logic [29:0] cal_time_i = '0, set_val_o;

  int total = 0, bad = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  rtc_apb_regs u_dut (.*);

  always #4 pclk = ~pclk;

  function automatic logic [29:0] pack(int y, int mo, int d, int h, int mi, int s);
    logic [3:0] yy = 4'(y - 2017);
    return {yy, 4'(mo), 5'(d), 5'(h), 6'(mi), 6'(s)};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard pop on every access phase
  always @(negedge pclk) begin
    if (psel && penable) begin
      check("R2 pready", {31'd0, pready}, 32'd1);
      if (exp_q.size() > 0) check(tag_q.pop_front(), prdata, exp_q.pop_front());
    end
  end

  task automatic apb(input logic wr, input logic [11:0] a, input logic [31:0] d,
                     input logic [31:0] exp, input string tag);
    @(posedge pclk); #1;
    psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge pclk); #1; penable = 1;
    @(posedge pclk); #1; psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic tick(input logic [29:0] t);
    @(posedge pclk); #1; cal_time_i = t;
    repeat (2) @(posedge pclk); #1; sec_tick_i = 1;
    repeat (6) @(posedge pclk); #1; sec_tick_i = 0;
    repeat (4) @(posedge pclk);
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge pclk);
    @(negedge pclk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge pclk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [29:0] t1, t2, sa, sb;
    logic rq;
    repeat (3) @(posedge pclk); #1; presetn = 1;
    idle(1);
    check("R1 reset irq", {31'd0, alarm_irq_o}, 32'd0);
    check("R5 reset req", {31'd0, set_req_o}, 32'd0);
    apb(0, TK, 0, 32'h0042_0000, "R1 reset read");

    t1 = pack(2020, 2, 29, 23, 59, 58);
    tick(t1);
    apb(0, TK, 0, {2'b00, t1}, "R3 snapshot after tick");
    cal_time_i = pack(2021, 3, 1, 0, 0, 0);
    idle(8);
    apb(0, TK, 0, {2'b00, t1}, "R3 no update without tick");
    apb(0, 12'h014, 0, 32'd0, "R4 wrong address read");
    check("R4 idle prdata", prdata, 32'd0);

    sa = pack(2025, 12, 31, 12, 34, 56);
    apb(1, 12'h014, {2'b01, sa}, 32'd0, "R4 wrong address write data");
    idle(1);
    check("R4 no request on wrong address", {31'd0, set_req_o}, 32'd0);
    apb(1, TK, {2'b00, sa}, 32'd0, "R7 code 00 write data");
    apb(1, TK, {2'b11, sa}, 32'd0, "R7 code 11 write data");
    idle(1);
    check("R7 no request on reserved codes", {31'd0, set_req_o}, 32'd0);
    tick(sa);
    check("R7 reserved code did not arm alarm", {31'd0, alarm_irq_o}, 32'd0);

    apb(1, TK, {2'b01, sa}, 32'd0, "R5 set write data");
    idle(1);
    check("R5 request toggled", {31'd0, set_req_o}, 32'd1);
    check("R5 set value", {2'b00, set_val_o}, {2'b00, sa});
    sb = pack(2030, 7, 4, 1, 2, 3);
    apb(1, TK, {2'b01, sb}, 32'd0, "R6 busy write data");
    idle(1);
    check("R6 value held while busy", {2'b00, set_val_o}, {2'b00, sa});
    check("R6 request held while busy", {31'd0, set_req_o}, 32'd1);
    set_ack_i = 1;
    idle(4);
    apb(1, TK, {2'b01, sb}, 32'd0, "R5 second set data");
    idle(1);
    rq = set_req_o;
    check("R5 request after ack", {31'd0, rq}, 32'd0);
    check("R5 value after ack", {2'b00, set_val_o}, {2'b00, sb});
    set_ack_i = 0;
    idle(4);

    apb(1, TK, {2'b10, 13'd0, 5'd10, 6'd20, 6'd30}, 32'd0, "R8 alarm write data");
    tick(pack(2018, 1, 1, 10, 20, 29));
    check("R8 no match", {31'd0, alarm_irq_o}, 32'd0);
    t2 = pack(2019, 6, 15, 10, 20, 30);
    tick(t2);
    check("R8 match on hms with other date", {31'd0, alarm_irq_o}, 32'd1);
    apb(0, TK, 0, {2'b00, t2}, "R1 read at alarm time");
    tick(pack(2019, 6, 15, 10, 20, 31));
    check("R9 irq sticky", {31'd0, alarm_irq_o}, 32'd1);
    apb(1, TK, {2'b10, 13'd0, 5'd1, 6'd1, 6'd1}, 32'd0, "R9 rearm write data");
    idle(1);
    check("R9 irq cleared by alarm write", {31'd0, alarm_irq_o}, 32'd0);
    tick(pack(2019, 6, 15, 1, 1, 1));
    check("R8 rearmed match", {31'd0, alarm_irq_o}, 32'd1);
    @(posedge pclk); #1; presetn = 0;
    idle(1);
    check("R9 irq cleared by reset", {31'd0, alarm_irq_o}, 32'd0);
    @(posedge pclk); #1; presetn = 1;
    apb(0, TK, 0, 32'h0042_0000, "R1 read after reset");
    idle(2);
    check("scoreboard drained", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule